// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt Flag

This block paces the slow housekeeping of a multi-channel audio generator. It counts CPU clock cycles and sends short clock pulses to the channel units. A quarter-frame pulse drives the envelope units and the triangle linear counter. A half-frame pulse drives the length counters and the sweep units. It also keeps a level-sensitive frame interrupt flag for the CPU.

The sequence runs through four step indices. The gaps between steps are uneven. Two settings written by the CPU shape it. One selects a long-frame (five-step) variant. The other masks the interrupt. Every such write restarts the sequence, and the restart keeps the odd/even alignment of the countdown that was in progress. A status-read pulse clears the interrupt flag. A region input selects one of two base step periods.

Top module: `apu_frame_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, all three outputs are low. The first quarter-frame pulse comes without a half-frame pulse, on rising edge P+2. Edge 1 is the first rising edge with rst_ni high.
- R2: The base period P is PERIOD_DEF (7458) when alt_region_i is 0 and PERIOD_ALT (8314) when it is 1. The input is sampled whenever a new step delay is loaded.
- R3: In four-step mode the pulses come in the repeating index order 1, 2, 3, 0. The gap after index 1 is P-2 cycles and every other gap is P cycles. A quarter pulse occurs at every step. The half pulse occurs only at indices 0 and 2.
- R4: In four-step mode with the mask clear, irq_o rises on the same edge as the index-0 pulses, and at no other step.
- R5: With mode_data_i bit 7 set (five-step mode), the gap from index 3 to index 0 is 2P-6 cycles and the frame flag is never set.
- R6: With mode_data_i bit 6 set (mask), the flag is never set. A write with bit 6 set clears the flag on its own edge.
- R7: A mode write with bit 6 clear leaves the frame flag unchanged.
- R8: A four-step write on edge w restarts at index 1. Its quarter pulse (without a half pulse) comes on edge w+P+((e-w+1) mod 2), where e is the edge on which the pending pulse was due. A step due in the write cycle is dropped.
- R9: A five-step write on edge w restarts at index 0. A quarter and a half pulse come on edge w+1.
- R10: A status_rd_i pulse clears the flag on its edge. If an index-0 step sets the flag on that same edge, the flag stays set.
- R11: Each strobe is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alt_region_i | input | 1 | 1 selects the alternate base period |
| mode_wr_i | input | 1 | Write strobe for the mode setting |
| mode_data_i | input | 8 | Write data: bit 7 five-step mode, bit 6 interrupt mask, others ignored |
| status_rd_i | input | 1 | Status read pulse, clears the frame flag |
| qtr_strobe_o | output | 1 | Quarter-frame clock pulse |
| half_strobe_o | output | 1 | Half-frame clock pulse |
| irq_o | output | 1 | Frame interrupt flag, level |

## Verification
The index-0 step can set the frame flag on the very edge where a status read clears it. The bench lines up a read pulse with the edge of a predicted index-0 pulse, and then expects both strobes high and the flag still set. A second coincidence is a mode write against a pending step. Here the bench takes the expected restart edge from the parity of the remaining gap, and runs cases where that parity is even and where it is odd.

// File: rtl/apu_frame_seq_pkg.sv
`timescale 1ns/1ps
package apu_frame_seq_pkg;

  typedef enum logic [1:0] {
    STEP0 = 2'd0,
    STEP1 = 2'd1,
    STEP2 = 2'd2,
    STEP3 = 2'd3
  } step_e;

  typedef struct packed {
    logic five_step;
    logic irq_mask;
  } mode_t;

  function automatic logic step_has_half(input step_e s);
    return (s == STEP0) || (s == STEP2);
  endfunction

endpackage

// File: rtl/fs_step_timer.sv
`timescale 1ns/1ps
module fs_step_timer #(
  parameter int CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [CW-1:0] restart_val_i,
  input  logic [CW-1:0] reload_val_i,
  output logic          due_o,
  output logic          parity_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign due_o    = (cnt_q <= CW'(1));
  assign parity_o = cnt_q[0];

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = restart_val_i;
    end else if (due_o) begin
      cnt_d = reload_val_i;
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fs_step_decode.sv
`timescale 1ns/1ps
module fs_step_decode
  import apu_frame_seq_pkg::*;
#(
  parameter int CW = 15
) (
  input  step_e         step_i,
  input  mode_t         mode_i,
  input  logic [CW-1:0] period_i,
  output logic          half_o,
  output logic          irq_req_o,
  output logic [CW-1:0] delay_o,
  output step_e         step_next_o
);

  always_comb begin
    half_o      = step_has_half(step_i);
    irq_req_o   = (step_i == STEP0) && !mode_i.five_step && !mode_i.irq_mask;
    delay_o     = period_i;
    step_next_o = STEP0;
    unique case (step_i)
      STEP0: step_next_o = STEP1;
      STEP1: begin
        step_next_o = STEP2;
        delay_o     = period_i - CW'(2);
      end
      STEP2: step_next_o = STEP3;
      STEP3: begin
        step_next_o = STEP0;
        if (mode_i.five_step) begin
          delay_o = period_i + period_i - CW'(6);
        end
      end
      default: step_next_o = STEP0;
    endcase
  end

endmodule

// File: rtl/fs_irq_latch.sv
`timescale 1ns/1ps
module fs_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/apu_frame_seq.sv
`timescale 1ns/1ps
module apu_frame_seq
  import apu_frame_seq_pkg::*;
#(
  parameter int PERIOD_DEF = 7458,
  parameter int PERIOD_ALT = 8314
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alt_region_i,
  input  logic       mode_wr_i,
  input  logic [7:0] mode_data_i,
  input  logic       status_rd_i,
  output logic       qtr_strobe_o,
  output logic       half_strobe_o,
  output logic       irq_o
);

  localparam int MAX_P = (PERIOD_ALT > PERIOD_DEF) ? PERIOD_ALT : PERIOD_DEF;
  localparam int CW    = $clog2(2 * MAX_P + 1);

  logic [CW-1:0] period;
  logic          restart, due, cnt_par, par, fire;
  logic [CW-1:0] restart_val, delay;
  mode_t         mode_q, mode_d, new_mode;
  step_e         step_q, step_d, step_next;
  logic          boot_q;
  logic          qtr_q, half_q, qtr_d, half_d;
  logic          step_half, irq_req, irq_set, irq_clr;
  logic          five_q, mask_q;
  logic          unused_data;

  assign unused_data = ^mode_data_i[5:0];

  assign period = alt_region_i ? CW'(PERIOD_ALT) : CW'(PERIOD_DEF);

  // Reset behaves as a write of zero with an odd leftover count.
  assign restart  = boot_q | mode_wr_i;
  assign new_mode = mode_wr_i ? mode_t'(mode_data_i[7:6]) : mode_t'(2'b00);
  assign par      = boot_q ? 1'b1 : cnt_par;

  always_comb begin
    restart_val = CW'(par);
    if (!new_mode.five_step) begin
      restart_val = CW'(par) + period;
    end
  end

  fs_step_timer #(.CW(CW)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restart_i     (restart),
    .restart_val_i (restart_val),
    .reload_val_i  (delay),
    .due_o         (due),
    .parity_o      (cnt_par)
  );

  fs_step_decode #(.CW(CW)) u_decode (
    .step_i      (step_q),
    .mode_i      (mode_q),
    .period_i    (period),
    .half_o      (step_half),
    .irq_req_o   (irq_req),
    .delay_o     (delay),
    .step_next_o (step_next)
  );

  // A write owns its cycle: a step due at the same time is dropped.
  assign fire    = due & ~restart;
  assign irq_set = fire & irq_req;
  assign irq_clr = status_rd_i | (mode_wr_i & mode_data_i[6]);

  fs_irq_latch u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .flag_o (irq_o)
  );

  always_comb begin
    step_d = step_q;
    mode_d = mode_q;
    if (restart) begin
      mode_d = new_mode;
      step_d = new_mode.five_step ? STEP0 : STEP1;
    end else if (fire) begin
      step_d = step_next;
    end
    qtr_d  = fire;
    half_d = fire & step_half;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      step_q <= STEP1;
      mode_q <= '0;
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      step_q <= step_d;
      mode_q <= mode_d;
      qtr_q  <= qtr_d;
      half_q <= half_d;
    end
  end

  assign qtr_strobe_o  = qtr_q;
  assign half_strobe_o = half_q;
  assign five_q        = mode_q.five_step;
  assign mask_q        = mode_q.irq_mask;

endmodule

// File: rtl/apu_frame_seq_chk.sv
`timescale 1ns/1ps
module apu_frame_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic qtr,
  input logic half,
  input logic irq,
  input logic rd,
  input logic wr,
  input logic wr_mask,
  input logic irq_set,
  input logic five_q,
  input logic mask_q
);

  a_r3_half_has_quarter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half |-> qtr);

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qtr |=> !qtr);

  a_r4_irq_rises_at_step0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq) |-> (qtr && half));

  a_r5_five_step_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (five_q && !wr) |=> !$rose(irq));

  a_r6_mask_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !wr) |=> !$rose(irq));

  a_r6_mask_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wr_mask) |=> !irq);

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !irq_set) |=> !irq);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set |=> irq);

endmodule

bind apu_frame_seq apu_frame_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .qtr     (qtr_strobe_o),
  .half    (half_strobe_o),
  .irq     (irq_o),
  .rd      (status_rd_i),
  .wr      (mode_wr_i),
  .wr_mask (mode_data_i[6]),
  .irq_set (irq_set),
  .five_q  (five_q),
  .mask_q  (mask_q)
);

// File: tb/apu_frame_seq_tb_top.sv
`timescale 1ns/1ps
module apu_frame_seq_tb_top;

  localparam int P  = 7458;
  localparam int PA = 8314;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alt = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       q, h, irq;
  int         cyc;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  apu_frame_seq dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .alt_region_i  (alt),
    .mode_wr_i     (wr),
    .mode_data_i   (wd),
    .status_rd_i   (rd),
    .qtr_strobe_o  (q),
    .half_strobe_o (h),
    .irq_o         (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic next_strobe(input int exp, input bit hexp, input string req);
    @(negedge clk);
    while (!q) @(negedge clk);
    chk(cyc == exp, req, cyc, exp);
    chk(h == hexp, req, int'(h), int'(hexp));
  endtask

  task automatic do_write(input int w, input logic [7:0] d);
    wait_until(w - 1);
    wr = 1'b1;
    wd = d;
    @(negedge clk);
    wr = 1'b0;
    wd = 8'h00;
  endtask

  // R1: reset state and first step
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!q && !h && !irq, "R1", int'({q, h, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!q && !h && !irq, "R1", int'({q, h, irq}), 0);
    next_strobe(P + 2, 1'b0, "R1");
    chk(irq == 1'b0, "R1", int'(irq), 0);
  endtask

  // R3 R4 R10: four-step order, flag at index 0, read clears
  task automatic t_four_step();
    next_strobe(2 * P, 1'b1, "R3");
    next_strobe(3 * P, 1'b0, "R3");
    next_strobe(4 * P, 1'b1, "R3");
    chk(irq == 1'b1, "R4", int'(irq), 1);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(irq == 1'b0, "R10", int'(irq), 0);
    next_strobe(5 * P, 1'b0, "R3");
    chk(irq == 1'b0, "R4", int'(irq), 0);
    next_strobe(6 * P - 2, 1'b1, "R3");
    next_strobe(7 * P - 2, 1'b0, "R3");
  endtask

  // R10: read on the same edge as the index-0 set
  task automatic t_read_collide();
    wait_until(8 * P - 3);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(cyc == 8 * P - 2 && q && h, "R10", int'({q, h}), 3);
    chk(irq == 1'b1, "R10", int'(irq), 1);
  endtask

  // R7 R8 R6: restarts with even and odd leftover, mask write
  task automatic t_restart();
    do_write(8 * P + 5, 8'h00);
    chk(irq == 1'b1, "R7", int'(irq), 1);
    next_strobe(9 * P + 5, 1'b0, "R8");
    do_write(9 * P + 15, 8'h40);
    chk(irq == 1'b0, "R6", int'(irq), 0);
    next_strobe(10 * P + 16, 1'b0, "R8");
    next_strobe(11 * P + 14, 1'b1, "R3");
    next_strobe(12 * P + 14, 1'b0, "R3");
    next_strobe(13 * P + 14, 1'b1, "R6");
    chk(irq == 1'b0, "R6", int'(irq), 0);
  endtask

  // R9 R5: five-step restart and long last gap
  task automatic t_five_step();
    int w;
    w = 13 * P + 20;
    do_write(w, 8'h80);
    next_strobe(w + 1, 1'b1, "R9");
    chk(irq == 1'b0, "R5", int'(irq), 0);
    next_strobe(w + 1 + P, 1'b0, "R5");
    next_strobe(w + 1 + 2 * P - 2, 1'b1, "R5");
    next_strobe(w + 1 + 3 * P - 2, 1'b0, "R5");
    next_strobe(w + 1 + 5 * P - 8, 1'b1, "R5");
    chk(irq == 1'b0, "R5", int'(irq), 0);
  endtask

  // R2: alternate region period
  task automatic t_region();
    int w;
    w = 18 * P + 20;
    wait_until(w - 3);
    alt = 1'b1;
    do_write(w, 8'h80);
    next_strobe(w + 1, 1'b1, "R9");
    next_strobe(w + 1 + PA, 1'b0, "R2");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_four_step();
    t_read_collide();
    t_restart();
    t_five_step();
    t_region();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule